// File: doc/BRIEF.md
# MSI target address decoder

This block sits on the write path that carries message-signalled interrupts. Each incoming write has an address and a 32-bit payload. The payload is the interrupt identity. The block breaks the address into five parts: a page offset, a guest index, a hart index and a group index, plus the remaining bits. The remaining bits must match a configured base address. When an address hits, the block forwards the identity to one of `NUM_HARTS` interrupt files as a single-cycle pulse.

The address layout is programmed through configuration inputs:
- the width of the guest field, which sits directly above the 4 KiB page;
- the width of the hart field, which sits directly above the guest field;
- the width of the group field;
- the bit position where the group field starts.

A default mode replaces all four settings with a standard layout:
- no guest bits;
- just enough hart bits to number every hart;
- no group bits;
- the group field starting at bit 24.

The block checks the layout. If the layout is impossible, it raises `config_error` and stops forwarding anything.

The file number is formed by placing the group index above the hart index. The guest index goes out with the pulse. A nonzero guest index marks the write as aimed at a guest-level file rather than the supervisor-level file.

Top module: `msi_target_decode`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `deliver_valid` = 0 and `deliver_sel` = 0.
- R2: Address bits [11:0] are the page offset. The guest index is the `G` bits starting at bit 12. The hart index is the `H` bits starting at bit 12+G. The group index is the `R` bits starting at bit `S`. On a delivery, `deliver_guest`, `deliver_hart` and `deliver_group` carry these fields, zero-extended.
- R3: A write hits only if every address bit outside the page, guest, hart and group fields equals the same bit of `cfg_base`. Bits of `cfg_base` that fall inside those fields are ignored. A write that does not hit produces no delivery.
- R4: Only a page offset of 0x000 or 0x004 is delivered. A write with any other offset is dropped.
- R5: A delivered write raises `deliver_valid` for exactly one cycle, in the cycle after `wr_valid` is sampled. In that cycle `deliver_id` equals the write payload.
- R6: The target file number is group × 2^H + hart. If this number is below `NUM_HARTS`, `deliver_sel` is one-hot with bit (target) set. If it is not below `NUM_HARTS`, the write is dropped. Whenever `deliver_valid` is 0, `deliver_sel` is all zero.
- R7: `deliver_to_guest` is 1 exactly when the delivered guest index is nonzero.
- R8: `config_error` = 1 when any of the following holds:
  - 12+G+H+R > `ADDR_W`;
  - S+R > `ADDR_W`;
  - R > 0 and S < 12+G+H.
  While `config_error` = 1, no write is delivered.
- R9: With `cfg_use_default` = 1, the decoder ignores the other configuration inputs and uses G=0, H=ceil(log2(`NUM_HARTS`)), R=0, S=24.
- R10: With group 0, hart h's supervisor page lies at `cfg_base` + h × 2^G × 4096. A write to that page is delivered with `deliver_hart` = h and `deliver_guest` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_use_default | input | 1 | Use the built-in default layout |
| cfg_guest_bits | input | CFG_W | Guest field width G |
| cfg_hart_bits | input | CFG_W | Hart field width H |
| cfg_group_bits | input | CFG_W | Group field width R |
| cfg_group_shift | input | CFG_W | Group field lowest bit S |
| cfg_base | input | ADDR_W | Base address for the bits outside the index fields |
| wr_valid | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | ID_W | Write payload (interrupt identity) |
| deliver_valid | output | 1 | One-cycle delivery pulse |
| deliver_sel | output | NUM_HARTS | One-hot selected interrupt file |
| deliver_group | output | ADDR_W-12 | Decoded group index |
| deliver_hart | output | ADDR_W-12 | Decoded hart index |
| deliver_guest | output | ADDR_W-12 | Decoded guest index |
| deliver_to_guest | output | 1 | Guest index is nonzero |
| deliver_id | output | ID_W | Delivered identity |
| config_error | output | 1 | Configuration is invalid |

## Verification
The assertions assume that the configuration inputs change only between writes and never in the same cycle as a `wr_valid` that they would affect. They also assume that `wr_valid` is a clean level sampled at the clock. The bench meets both conditions:
- it changes the configuration and drives each write on the falling clock edge;
- it holds each write for exactly one rising edge;
- it reads the pulse before issuing the next write.

The address sweeps cover every reachable pair of file number and guest index for several layouts. Each address is built from a base whose index-field bits are deliberately scrambled, which shows that bits of `cfg_base` inside the index fields are ignored.

// File: rtl/msi_dec_pkg.sv
// Package: shared constants, the page-offset classification type, and the
// bit-range helpers used by the MSI target address decoder.
// Assumes: address widths of at most 64 bits.
package msi_dec_pkg;

    localparam int PAGE_W = 12;

    typedef enum logic [1:0] {
        OFS_WORD_LO = 2'd0,
        OFS_WORD_HI = 2'd1,
        OFS_OTHER   = 2'd2
    } page_ofs_e;

    // Mask with ones in bits [lo, lo+width) and zeros elsewhere.
    function automatic logic [63:0] range_mask(input int lo, input int width);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            m[i] = (i >= lo) && (i < lo + width);
        end
        return m;
    endfunction

    // Field of `width` bits starting at bit `lo`, zero-extended.
    function automatic logic [63:0] field_pick(input logic [63:0] a, input int lo, input int width);
        return (a >> lo) & range_mask(0, width);
    endfunction

endpackage

// File: rtl/msi_cfg_resolve.sv
// Module: resolves the effective address layout, either from the
// configuration inputs or from the built-in default, and checks it.
// Outputs the effective field widths and group position, a mask of every
// index bit (page, guest, hart, group), and an invalid-configuration flag.
// Assumes: ADDR_W > PAGE_W and ADDR_W <= 64.
module msi_cfg_resolve
    import msi_dec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_HARTS = 8,
    parameter int CFG_W     = 6
) (
    input  logic              use_default,
    input  logic [CFG_W-1:0]  guest_bits,
    input  logic [CFG_W-1:0]  hart_bits,
    input  logic [CFG_W-1:0]  group_bits,
    input  logic [CFG_W-1:0]  group_shift,
    output logic [CFG_W-1:0]  eff_guest,
    output logic [CFG_W-1:0]  eff_hart,
    output logic [CFG_W-1:0]  eff_group,
    output logic [CFG_W-1:0]  eff_shift,
    output logic [ADDR_W-1:0] index_mask,
    output logic              cfg_bad
);

    localparam int DEF_HART  = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 0;
    localparam int DEF_SHIFT = 2 * PAGE_W;

    int          low_end;
    int          grp_end;
    logic [63:0] mask64;

    // Pick the effective layout: the default one or the programmed one.
    always_comb begin
        if (use_default) begin
            eff_guest = '0;
            eff_hart  = CFG_W'(DEF_HART);
            eff_group = '0;
            eff_shift = CFG_W'(DEF_SHIFT);
        end else begin
            eff_guest = guest_bits;
            eff_hart  = hart_bits;
            eff_group = group_bits;
            eff_shift = group_shift;
        end
    end

    // Validate the layout and build the mask of index bits.
    always_comb begin
        low_end = PAGE_W + int'(eff_guest) + int'(eff_hart);
        grp_end = int'(eff_shift) + int'(eff_group);
        cfg_bad = (low_end + int'(eff_group) > ADDR_W)
               || (grp_end > ADDR_W)
               || ((eff_group != '0) && (int'(eff_shift) < low_end));
        mask64     = range_mask(0, low_end) | range_mask(int'(eff_shift), int'(eff_group));
        index_mask = mask64[ADDR_W-1:0];
    end

endmodule

// File: rtl/msi_addr_split.sv
// Module: splits a write address into guest, hart and group indices,
// compares the non-index bits with the base address, and classifies the
// page offset.
// Assumes: the layout inputs come from msi_cfg_resolve.
module msi_addr_split
    import msi_dec_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int CFG_W   = 6,
    parameter int FIELD_W = ADDR_W - PAGE_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  base,
    input  logic [CFG_W-1:0]   eff_guest,
    input  logic [CFG_W-1:0]   eff_hart,
    input  logic [CFG_W-1:0]   eff_group,
    input  logic [CFG_W-1:0]   eff_shift,
    input  logic [ADDR_W-1:0]  index_mask,
    output logic [FIELD_W-1:0] guest_idx,
    output logic [FIELD_W-1:0] hart_idx,
    output logic [FIELD_W-1:0] group_idx,
    output logic               base_match,
    output page_ofs_e          ofs_kind
);

    logic [63:0] a64;
    logic [63:0] g64;
    logic [63:0] h64;
    logic [63:0] r64;

    // Extract the three index fields at their configured positions.
    always_comb begin
        a64       = 64'(addr);
        g64       = field_pick(a64, PAGE_W, int'(eff_guest));
        h64       = field_pick(a64, PAGE_W + int'(eff_guest), int'(eff_hart));
        r64       = field_pick(a64, int'(eff_shift), int'(eff_group));
        guest_idx = g64[FIELD_W-1:0];
        hart_idx  = h64[FIELD_W-1:0];
        group_idx = r64[FIELD_W-1:0];
    end

    // Compare every non-index bit with the base address.
    always_comb begin
        base_match = (((addr ^ base) & ~index_mask) == '0);
    end

    // Classify the offset within the page.
    always_comb begin
        if (addr[PAGE_W-1:0] == PAGE_W'(0)) begin
            ofs_kind = OFS_WORD_LO;
        end else if (addr[PAGE_W-1:0] == PAGE_W'(4)) begin
            ofs_kind = OFS_WORD_HI;
        end else begin
            ofs_kind = OFS_OTHER;
        end
    end

endmodule

// File: rtl/msi_target_select.sv
// Module: maps a (group, hart) pair to a one-hot interrupt file select.
// File k is chosen when hart equals the low H bits of k and group equals
// k shifted right by H. There is one comparator per file.
// Assumes: hart and group are already zero-extended to their field widths.
module msi_target_select
    import msi_dec_pkg::*;
#(
    parameter int FIELD_W   = 20,
    parameter int NUM_HARTS = 8,
    parameter int CFG_W     = 6
) (
    input  logic [FIELD_W-1:0]   hart_idx,
    input  logic [FIELD_W-1:0]   group_idx,
    input  logic [CFG_W-1:0]     hart_bits,
    output logic [NUM_HARTS-1:0] sel,
    output logic                 in_range
);

    for (genvar k = 0; k < NUM_HARTS; k++) begin : g_file
        logic [63:0] kv;
        logic [63:0] k_lo;
        logic [63:0] k_hi;
        // Decide whether this write targets file k.
        always_comb begin
            kv     = 64'(k);
            k_lo   = kv & range_mask(0, int'(hart_bits));
            k_hi   = kv >> hart_bits;
            sel[k] = (64'(hart_idx) == k_lo) && (64'(group_idx) == k_hi);
        end
    end

    // The target is in range when some file matched.
    always_comb begin
        in_range = |sel;
    end

endmodule

// File: rtl/msi_target_decode.sv
// Module (top): MSI target address decoder. Resolves the layout, splits
// each write address, and registers a one-cycle delivery pulse with the
// file select, the index fields and the identity.
// Assumes: the configuration is stable around each write; synchronous
// active-low reset.
module msi_target_decode
    import msi_dec_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int ID_W      = 32,
    parameter int NUM_HARTS = 8,
    parameter int CFG_W     = $clog2(ADDR_W) + 1,
    parameter int FIELD_W   = ADDR_W - PAGE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_use_default,
    input  logic [CFG_W-1:0]     cfg_guest_bits,
    input  logic [CFG_W-1:0]     cfg_hart_bits,
    input  logic [CFG_W-1:0]     cfg_group_bits,
    input  logic [CFG_W-1:0]     cfg_group_shift,
    input  logic [ADDR_W-1:0]    cfg_base,
    input  logic                 wr_valid,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [ID_W-1:0]      wr_data,
    output logic                 deliver_valid,
    output logic [NUM_HARTS-1:0] deliver_sel,
    output logic [FIELD_W-1:0]   deliver_group,
    output logic [FIELD_W-1:0]   deliver_hart,
    output logic [FIELD_W-1:0]   deliver_guest,
    output logic                 deliver_to_guest,
    output logic [ID_W-1:0]      deliver_id,
    output logic                 config_error
);

    logic [CFG_W-1:0]     eff_guest;
    logic [CFG_W-1:0]     eff_hart;
    logic [CFG_W-1:0]     eff_group;
    logic [CFG_W-1:0]     eff_shift;
    logic [ADDR_W-1:0]    index_mask;
    logic                 cfg_bad;
    logic [FIELD_W-1:0]   guest_idx;
    logic [FIELD_W-1:0]   hart_idx;
    logic [FIELD_W-1:0]   group_idx;
    logic                 base_match;
    page_ofs_e            ofs_kind;
    logic [NUM_HARTS-1:0] sel_c;
    logic                 in_range;
    logic                 fire;

    msi_cfg_resolve #(
        .ADDR_W    (ADDR_W),
        .NUM_HARTS (NUM_HARTS),
        .CFG_W     (CFG_W)
    ) u_cfg (
        .use_default (cfg_use_default),
        .guest_bits  (cfg_guest_bits),
        .hart_bits   (cfg_hart_bits),
        .group_bits  (cfg_group_bits),
        .group_shift (cfg_group_shift),
        .eff_guest   (eff_guest),
        .eff_hart    (eff_hart),
        .eff_group   (eff_group),
        .eff_shift   (eff_shift),
        .index_mask  (index_mask),
        .cfg_bad     (cfg_bad)
    );

    msi_addr_split #(
        .ADDR_W  (ADDR_W),
        .CFG_W   (CFG_W),
        .FIELD_W (FIELD_W)
    ) u_split (
        .addr       (wr_addr),
        .base       (cfg_base),
        .eff_guest  (eff_guest),
        .eff_hart   (eff_hart),
        .eff_group  (eff_group),
        .eff_shift  (eff_shift),
        .index_mask (index_mask),
        .guest_idx  (guest_idx),
        .hart_idx   (hart_idx),
        .group_idx  (group_idx),
        .base_match (base_match),
        .ofs_kind   (ofs_kind)
    );

    msi_target_select #(
        .FIELD_W   (FIELD_W),
        .NUM_HARTS (NUM_HARTS),
        .CFG_W     (CFG_W)
    ) u_sel (
        .hart_idx  (hart_idx),
        .group_idx (group_idx),
        .hart_bits (eff_hart),
        .sel       (sel_c),
        .in_range  (in_range)
    );

    // Drive the configuration error flag.
    always_comb begin
        config_error = cfg_bad;
    end

    // A write is delivered when the layout is valid, the base matches,
    // the offset is allowed and the target file exists.
    always_comb begin
        fire = wr_valid && !cfg_bad && base_match && in_range
            && (ofs_kind != OFS_OTHER);
    end

    // Register the delivery pulse and its select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver_valid <= 1'b0;
            deliver_sel   <= '0;
        end else begin
            deliver_valid <= fire;
            deliver_sel   <= fire ? sel_c : '0;
        end
    end

    // Capture the payload fields of a delivered write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deliver_group    <= '0;
            deliver_hart     <= '0;
            deliver_guest    <= '0;
            deliver_to_guest <= 1'b0;
            deliver_id       <= '0;
        end else if (fire) begin
            deliver_group    <= group_idx;
            deliver_hart     <= hart_idx;
            deliver_guest    <= guest_idx;
            deliver_to_guest <= (guest_idx != '0);
            deliver_id       <= wr_data;
        end
    end

    p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> $past(wr_valid));

    p_id_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> (deliver_id == $past(wr_data)));

    p_cfg_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> !$past(config_error));

    p_ofs_allowed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> (($past(wr_addr[PAGE_W-1:0]) == PAGE_W'(0))
                        || ($past(wr_addr[PAGE_W-1:0]) == PAGE_W'(4))));

    p_sel_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        deliver_valid |-> ($countones(deliver_sel) == 1));

    p_sel_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !deliver_valid |-> (deliver_sel == '0));

endmodule

// File: tb/msi_target_decode_bench.sv
`timescale 1ns/1ps
module msi_target_decode_bench;

    localparam int ADDR_W = 32;
    localparam int ID_W   = 32;
    localparam int NH     = 8;
    localparam int CFG_W  = 6;
    localparam int FW     = ADDR_W - 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_use_default = 1'b0;
    logic [CFG_W-1:0]  cfg_guest_bits = '0;
    logic [CFG_W-1:0]  cfg_hart_bits = 6'd3;
    logic [CFG_W-1:0]  cfg_group_bits = '0;
    logic [CFG_W-1:0]  cfg_group_shift = 6'd24;
    logic [ADDR_W-1:0] cfg_base = 32'hA4F3_7ABC;
    logic              wr_valid = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [ID_W-1:0]   wr_data = '0;
    logic              deliver_valid;
    logic [NH-1:0]     deliver_sel;
    logic [FW-1:0]     deliver_group;
    logic [FW-1:0]     deliver_hart;
    logic [FW-1:0]     deliver_guest;
    logic              deliver_to_guest;
    logic [ID_W-1:0]   deliver_id;
    logic              config_error;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    msi_target_decode u_msi_target_decode (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_use_default  (cfg_use_default),
        .cfg_guest_bits   (cfg_guest_bits),
        .cfg_hart_bits    (cfg_hart_bits),
        .cfg_group_bits   (cfg_group_bits),
        .cfg_group_shift  (cfg_group_shift),
        .cfg_base         (cfg_base),
        .wr_valid         (wr_valid),
        .wr_addr          (wr_addr),
        .wr_data          (wr_data),
        .deliver_valid    (deliver_valid),
        .deliver_sel      (deliver_sel),
        .deliver_group    (deliver_group),
        .deliver_hart     (deliver_hart),
        .deliver_guest    (deliver_guest),
        .deliver_to_guest (deliver_to_guest),
        .deliver_id       (deliver_id),
        .config_error     (config_error)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the falling edge after the capture.
    task automatic send(input logic [31:0] a, input logic [31:0] d);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        @(posedge clk);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic set_cfg(input int g, input int h, input int r, input int s);
        cfg_guest_bits  = CFG_W'(g);
        cfg_hart_bits   = CFG_W'(h);
        cfg_group_bits  = CFG_W'(r);
        cfg_group_shift = CFG_W'(s);
    endtask

    // Base with every index-field bit cleared, for layout (g,h,r,s).
    function automatic logic [31:0] clean_base(input int g, input int h, input int r, input int s);
        logic [31:0] b;
        b = cfg_base;
        for (int i = 0; i < 32; i++) begin
            if (i < 12 + g + h || (i >= s && i < s + r)) b[i] = 1'b0;
        end
        return b;
    endfunction

    task automatic sweep(input int g, input int h, input int r, input int s);
        logic [31:0] b;
        logic [31:0] a;
        logic [31:0] d;
        int grp;
        int hrt;
        set_cfg(g, h, r, s);
        #1;
        chk("R8 valid layout no error", 64'(config_error), 64'd0);
        b = clean_base(g, h, r, s);
        for (int t = 0; t < NH + 2; t++) begin
            grp = t >> h;
            hrt = t & ((1 << h) - 1);
            if (grp < (1 << r)) begin
                for (int gu = 0; gu < (1 << g); gu++) begin
                    a = b | (32'(gu) << 12) | (32'(hrt) << (12 + g)) | (32'(grp) << s)
                          | ((gu % 2 == 1) ? 32'd4 : 32'd0);
                    d = 32'h5EED_0000 + 32'(t * 64 + gu + s * 4096);
                    send(a, d);
                    if (t < NH) begin
                        chk("R5 deliver pulse", 64'(deliver_valid), 64'd1);
                        chk("R6 one-hot select", 64'(deliver_sel), 64'(1) << t);
                        chk("R2 hart field", 64'(deliver_hart), 64'(hrt));
                        chk("R2 guest field", 64'(deliver_guest), 64'(gu));
                        chk("R2 group field", 64'(deliver_group), 64'(grp));
                        chk("R7 guest flag", 64'(deliver_to_guest), 64'(gu != 0));
                        chk("R5 identity", 64'(deliver_id), 64'(d));
                    end else begin
                        chk("R6 out-of-range dropped", 64'(deliver_valid), 64'd0);
                        chk("R6 select idle", 64'(deliver_sel), 64'd0);
                    end
                end
            end
        end
        send(b | 32'h8, 32'h1);
        chk("R4 offset 8 dropped", 64'(deliver_valid), 64'd0);
        send(b | 32'hFFC, 32'h2);
        chk("R4 offset FFC dropped", 64'(deliver_valid), 64'd0);
        send((b | 32'd0) ^ 32'h8000_0000, 32'h3);
        chk("R3 base mismatch dropped", 64'(deliver_valid), 64'd0);
        chk("R6 select idle after miss", 64'(deliver_sel), 64'd0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset valid", 64'(deliver_valid), 64'd0);
        chk("R1 reset select", 64'(deliver_sel), 64'd0);
        wr_valid = 1'b1;
        wr_addr  = clean_base(0, 3, 0, 24);
        @(posedge clk);
        @(negedge clk);
        chk("R1 write under reset ignored", 64'(deliver_valid), 64'd0);
        wr_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        sweep(0, 3, 0, 24);
        sweep(1, 2, 1, 24);
        sweep(2, 1, 1, 20);
        sweep(0, 2, 1, 14);
        sweep(1, 1, 2, 28);
        sweep(0, 2, 2, 24);

        // R5: pulse lasts one cycle.
        set_cfg(0, 3, 0, 24);
        b = clean_base(0, 3, 0, 24);
        send(b | (32'd2 << 12), 32'hABCD_0001);
        chk("R5 pulse high", 64'(deliver_valid), 64'd1);
        @(posedge clk);
        @(negedge clk);
        chk("R5 pulse one cycle", 64'(deliver_valid), 64'd0);

        // R10: region layout with G=2.
        set_cfg(2, 3, 0, 24);
        b = clean_base(2, 3, 0, 24);
        for (int h = 0; h < NH; h++) begin
            send(b + 32'(h * 4 * 4096), 32'h7000 + 32'(h));
            chk("R10 region hart", 64'(deliver_hart), 64'(h));
            chk("R10 region valid", 64'(deliver_valid), 64'd1);
            chk("R10 region guest", 64'(deliver_guest), 64'd0);
        end

        // R8: invalid layouts.
        set_cfg(10, 10, 1, 24);
        #1;
        chk("R8 width sum too large", 64'(config_error), 64'd1);
        send(clean_base(10, 10, 1, 24), 32'h11);
        chk("R8 blocked delivery", 64'(deliver_valid), 64'd0);
        set_cfg(0, 3, 2, 31);
        #1;
        chk("R8 group beyond top", 64'(config_error), 64'd1);
        set_cfg(0, 3, 1, 13);
        #1;
        chk("R8 group overlaps hart", 64'(config_error), 64'd1);
        send(clean_base(0, 3, 1, 13), 32'h12);
        chk("R8 overlap blocked", 64'(deliver_valid), 64'd0);
        set_cfg(0, 3, 1, 15);
        #1;
        chk("R8 adjacent group ok", 64'(config_error), 64'd0);
        set_cfg(0, 3, 0, 32);
        #1;
        chk("R8 shift at width ok", 64'(config_error), 64'd0);
        set_cfg(0, 3, 0, 33);
        #1;
        chk("R8 shift past width", 64'(config_error), 64'd1);

        // R9: default layout overrides invalid programmed values.
        set_cfg(10, 10, 1, 13);
        cfg_use_default = 1'b1;
        #1;
        chk("R9 default no error", 64'(config_error), 64'd0);
        b = clean_base(0, 3, 0, 24);
        send(b + 32'(5 * 4096), 32'h9999);
        chk("R9 default valid", 64'(deliver_valid), 64'd1);
        chk("R9 default select", 64'(deliver_sel), 64'(1) << 5);
        chk("R9 default guest", 64'(deliver_guest), 64'd0);
        cfg_use_default = 1'b0;

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule